// File: doc/BRIEF.md
# Shared Memory Port Stall Controller

This block is the control logic for a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) that has a single memory port. Both instruction fetch and data loads and stores use that port. Every cycle the controller checks whether the instruction sitting in the memory stage is a load or a store. When it is, the data reference gets the port. The fetch address is frozen, and a no-op word is placed into the fetch/decode register instead of a fetched instruction. That lost fetch slot then moves down the pipeline as an empty slot.

The controller owns the fetch address register and a small valid chain that shadows the fetch/decode, decode/execute and execute/memory registers. Memory-op flags from the datapath are trusted only when a valid instruction occupies the memory stage. An external freeze request, such as a cache miss, stops every stage at once and holds the fetch address. Since every memory access takes one cycle, each load or store costs exactly one fetch slot.

Top module: `shport_stall_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the fetch address is 0, the port serves fetch (`mem_sel_data`=0, `mem_addr`=0), all five stage enables are 1 and `ifid_bubble` is 0.
- R2: When the memory stage holds a valid instruction with `mem_is_load` or `mem_is_store` set, the port serves data: `mem_sel_data`=1 and `mem_addr`=`mem_daddr` in that same cycle.
- R3: When the port serves fetch, `mem_addr` equals the fetch address, and without a freeze the fetch address grows by 4 at the next edge.
- R4: In a cycle where data takes the port, `pc_hold`=1 and the fetch address keeps its value across the next edge.
- R5: In a port-conflict cycle without a freeze, `ifid_bubble`=1 and `ifid_word`=0 (the no-op encoding, whose opcode field bits [31:30]=00 enables neither a register write nor a memory access). The fetch enable `stage_en[0]` is 0, and the four pipeline-register enables `stage_en[4:1]` (bit 1 fetch/decode, bit 2 decode/execute, bit 3 execute/memory, bit 4 memory/write-back) are 1, so older instructions keep moving.
- R6: While `stall_req`=1, `stage_en` is all zeros, `pc_hold`=1, `ifid_bubble`=0, and the fetch address does not change.
- R7: For the first three cycles after reset the memory stage is empty, and the memory-op flags are ignored: the port serves fetch.
- R8: An inserted bubble carries no valid bit. When it reaches the memory stage (three advancing edges later), asserted memory-op flags are ignored and the port serves fetch.
- R9: When the port serves fetch, `ifid_word` equals `mem_rdata`.
- R10: With no freezes, a program of N instructions followed by non-memory instructions reaches fetch address 4*(N+4) exactly N+4+K cycles after reset, where K is its number of loads and stores. Back-to-back memory-stage loads and stores each cost one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_is_store | input | 1 | Memory-stage instruction is a store |
| mem_daddr | input | ADDR_W | Memory-stage effective address |
| mem_rdata | input | DATA_W | Word read from the shared port |
| stall_req | input | 1 | Freeze request for all stages |
| mem_addr | output | ADDR_W | Address driven to the shared port |
| mem_sel_data | output | 1 | 1 = port serves data, 0 = fetch |
| ifid_word | output | DATA_W | Word to load into fetch/decode register |
| pc_o | output | ADDR_W | Current fetch address |
| pc_hold | output | 1 | Fetch address held this cycle |
| ifid_bubble | output | 1 | No-op inserted into fetch/decode |
| stage_en | output | 5 | Enables: fetch, IF/ID, ID/EX, EX/MEM, MEM/WB |

## Verification
Suppose the valid chain goes wrong. A lost valid bit shows up three advancing cycles later: a real load leaves `mem_sel_data` low and `mem_addr` on the fetch address. A spurious valid bit lets junk flags steal the port in a cycle where the bench expects a fetch. A fetch address that steps during a conflict appears at `pc_o` on the next edge, and it also shifts the completion cycle of the timing programs. Flags are driven at random whenever the shadow model holds the memory stage empty, so mistakes in valid tracking show up within a few cycles.

// File: rtl/shport_pkg.sv
package shport_pkg;
  localparam int STG_FETCH = 0;
  localparam int STG_IFID  = 1;
  localparam int STG_COUNT = 5;

  // Data reference claims the port only for a live memory-stage instruction.
  function automatic logic claims_port(input logic mem_valid, input logic is_ld,
                                       input logic is_st);
    return mem_valid & (is_ld | is_st);
  endfunction

  // Freeze stops everything; a port claim stops only the fetch step.
  function automatic logic [STG_COUNT-1:0] stage_enables(input logic freeze,
                                                         input logic claim);
    logic [STG_COUNT-1:0] en;
    en = freeze ? '0 : '1;
    if (claim) en[STG_FETCH] = 1'b0;
    return en;
  endfunction
endpackage

// File: rtl/shport_pc.sv
module shport_pc #(
  parameter int ADDR_W = 16,
  parameter int STEP   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  output logic [ADDR_W-1:0] pc_o
);
  function automatic logic [ADDR_W-1:0] next_fetch(input logic [ADDR_W-1:0] cur);
    return cur + ADDR_W'(STEP);
  endfunction

  logic [ADDR_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (!hold) pc_q <= next_fetch(pc_q);
  end

  assign pc_o = pc_q;

  // R4 / R6: a held cycle leaves the fetch address unchanged
  a_r4_hold_keeps_pc: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> pc_q == $past(pc_q));
  // R3: a fetch cycle steps the address by one word
  a_r3_step_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> pc_q == $past(pc_q) + ADDR_W'(STEP));
endmodule

// File: rtl/shport_valid.sv
module shport_valid (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic fill,
  output logic v_ifid,
  output logic v_mem
);
  logic v_ifid_q, v_idex_q, v_exmem_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_ifid_q  <= 1'b0;
      v_idex_q  <= 1'b0;
      v_exmem_q <= 1'b0;
    end else if (adv) begin
      v_ifid_q  <= fill;
      v_idex_q  <= v_ifid_q;
      v_exmem_q <= v_idex_q;
    end
  end

  assign v_ifid = v_ifid_q;
  assign v_mem  = v_exmem_q;

  // R6: frozen cycles keep the whole valid chain
  a_r6_chain_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(v_mem) && $stable(v_ifid));
  // R8: an empty slot in decode/execute reaches memory stage empty
  a_r8_empty_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !v_idex_q) |=> !v_exmem_q);
endmodule

// File: rtl/shport_portsel.sv
module shport_portsel #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] NOP_WORD = 32'h0
) (
  input  logic              claim,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] daddr,
  input  logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] port_addr,
  output logic              port_is_data,
  output logic [DATA_W-1:0] fetch_word
);
  localparam logic [DATA_W-1:0] NOP_W = DATA_W'(NOP_WORD);

  always_comb begin
    port_is_data = claim;
    port_addr    = claim ? daddr : pc;
    fetch_word   = claim ? NOP_W : rdata;
  end
endmodule

// File: rtl/shport_stall_ctrl.sv
module shport_stall_ctrl #(
  parameter int          ADDR_W   = 16,
  parameter int          DATA_W   = 32,
  parameter int          STEP     = 4,
  parameter logic [31:0] NOP_WORD = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_is_load,
  input  logic              mem_is_store,
  input  logic [ADDR_W-1:0] mem_daddr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              stall_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_data,
  output logic [DATA_W-1:0] ifid_word,
  output logic [ADDR_W-1:0] pc_o,
  output logic              pc_hold,
  output logic              ifid_bubble,
  output logic [4:0]        stage_en
);
  import shport_pkg::*;

  localparam logic [DATA_W-1:0] NOP_W = DATA_W'(NOP_WORD);

  // Named internal events
  logic                 v_mem, v_ifid;
  logic                 port_claim;
  logic [STG_COUNT-1:0] en_vec;
  logic                 fetch_go;

  assign port_claim = claims_port(v_mem, mem_is_load, mem_is_store);
  assign en_vec     = stage_enables(stall_req, port_claim);
  assign fetch_go   = en_vec[STG_FETCH];

  genvar gi;
  generate
    for (gi = 0; gi < STG_COUNT; gi++) begin : g_en
      assign stage_en[gi] = en_vec[gi];
    end
  endgenerate

  assign pc_hold     = !fetch_go;
  assign ifid_bubble = port_claim && !stall_req;

  shport_pc #(.ADDR_W(ADDR_W), .STEP(STEP)) u_pc (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (pc_hold),
    .pc_o  (pc_o)
  );

  shport_valid u_valid (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (en_vec[STG_IFID]),
    .fill   (!port_claim),
    .v_ifid (v_ifid),
    .v_mem  (v_mem)
  );

  shport_portsel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NOP_WORD(NOP_WORD)) u_sel (
    .claim        (port_claim),
    .pc           (pc_o),
    .daddr        (mem_daddr),
    .rdata        (mem_rdata),
    .port_addr    (mem_addr),
    .port_is_data (mem_sel_data),
    .fetch_word   (ifid_word)
  );

  // R2: a live memory-stage reference owns the port this cycle
  a_r2_data_owns_port: assert property (@(posedge clk) disable iff (!rst_n)
    (v_mem && (mem_is_load || mem_is_store)) |-> (mem_sel_data && mem_addr == mem_daddr));
  // R5: a data cycle never advances fetch
  a_r5_no_fetch_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_data |-> !stage_en[STG_FETCH]);
  // R5: inserted bubble is the no-op word
  a_r5_bubble_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_bubble |-> ifid_word == NOP_W);
  // R6: a freeze stops every stage and inserts nothing
  a_r6_freeze_all: assert property (@(posedge clk) disable iff (!rst_n)
    stall_req |-> (stage_en == '0 && !ifid_bubble && pc_hold));
  // R8: the fetch/decode register holds an empty slot after a bubble
  a_r8_bubble_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    ifid_bubble |=> !v_ifid);
  // R7: an empty memory stage never takes the port
  a_r7_empty_no_claim: assert property (@(posedge clk) disable iff (!rst_n)
    !v_mem |-> !mem_sel_data);
endmodule

// File: tb/shport_stall_ctrl_tb.sv
module shport_stall_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mem_is_load = 1'b0, mem_is_store = 1'b0, stall_req = 1'b0;
  logic [AW-1:0] mem_daddr = '0;
  logic [DW-1:0] mem_rdata = '0;
  logic [AW-1:0] mem_addr, pc_o;
  logic          mem_sel_data, pc_hold, ifid_bubble;
  logic [DW-1:0] ifid_word;
  logic [4:0]    stage_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  shport_stall_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mem_is_load(mem_is_load), .mem_is_store(mem_is_store),
    .mem_daddr(mem_daddr), .mem_rdata(mem_rdata), .stall_req(stall_req),
    .mem_addr(mem_addr), .mem_sel_data(mem_sel_data), .ifid_word(ifid_word),
    .pc_o(pc_o), .pc_hold(pc_hold), .ifid_bubble(ifid_bubble), .stage_en(stage_en)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // Opcode field [31:30]: 00 no-op, 01 load, 10 store, 11 ALU
  logic [DW-1:0] prog_mem [64];
  logic [AW-1:0] m_pc;
  logic          mv_ifid, mv_idex, mv_exmem;
  logic [DW-1:0] mi_ifid, mi_idex, mi_exmem;
  int            junk_pct, stall_pct, cyc;

  function automatic bit is_memop(input logic [DW-1:0] w);
    return w[31:30] == 2'b01 || w[31:30] == 2'b10;
  endfunction

  function automatic logic [4:0] exp_en(input logic st, input logic cl);
    if (st) return 5'b00000;
    return cl ? 5'b11110 : 5'b11111;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = '0; mv_ifid = 0; mv_idex = 0; mv_exmem = 0;
    mi_ifid = '0; mi_idex = '0; mi_exmem = '0; cyc = 0;
  endtask

  // Called just after a falling edge; ends on the next falling edge.
  task automatic step();
    logic cl, junk;
    logic [DW-1:0] fw;
    junk = 0;
    stall_req = ($urandom % 100) < stall_pct;
    mem_daddr = AW'($urandom);
    if (mv_exmem) begin
      mem_is_load  = mi_exmem[31:30] == 2'b01;
      mem_is_store = mi_exmem[31:30] == 2'b10;
    end else if (($urandom % 100) < junk_pct) begin
      mem_is_load  = $urandom % 2;
      mem_is_store = !mem_is_load;
      junk = 1;
    end else begin
      mem_is_load = 0; mem_is_store = 0;
    end
    cl = mv_exmem && (mem_is_load || mem_is_store);
    fw = prog_mem[m_pc[7:2]];
    mem_rdata = cl ? $urandom : fw;
    #1;
    if (cl) begin
      chk("R2 sel", mem_sel_data, 1);
      chk("R2 addr", mem_addr, mem_daddr);
    end else if (junk) begin
      chk(cyc < 3 ? "R7 sel" : "R8 sel", mem_sel_data, 0);
      chk(cyc < 3 ? "R7 addr" : "R8 addr", mem_addr, m_pc);
    end else begin
      chk("R3 sel", mem_sel_data, 0);
      chk("R3 addr", mem_addr, m_pc);
    end
    chk("R3 pc", pc_o, m_pc);
    chk(stall_req ? "R6 en" : "R5 en", stage_en, exp_en(stall_req, cl));
    chk(stall_req ? "R6 hold" : "R4 hold", pc_hold, stall_req || cl);
    chk(stall_req ? "R6 bubble" : "R5 bubble", ifid_bubble, cl && !stall_req);
    if (!cl) chk("R9 word", ifid_word, mem_rdata);
    else     chk("R5 word", ifid_word, 0);
    if (!stall_req) begin
      mv_exmem = mv_idex; mi_exmem = mi_idex;
      mv_idex = mv_ifid;  mi_idex = mi_ifid;
      if (cl) begin mv_ifid = 0; mi_ifid = '0; end
      else begin mv_ifid = 1; mi_ifid = fw; m_pc = m_pc + 4; end
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; stall_req = 0; mem_is_load = 1; mem_is_store = 0; mem_rdata = '0;
    #1;
    chk("R1 pc", pc_o, 0);
    chk("R1 sel", mem_sel_data, 0);
    chk("R1 addr", mem_addr, 0);
    chk("R1 en", stage_en, 5'b11111);
    chk("R1 bubble", ifid_bubble, 0);
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic load_prog(input int n, input logic [63:0] mask);
    for (int i = 0; i < 64; i++) begin
      if (i < n && mask[i]) prog_mem[i] = (i % 2 == 0) ? (32'h4000_0000 | i) : (32'h8000_0000 | i);
      else                  prog_mem[i] = 32'hC000_0000 | i;
    end
  endtask

  task automatic timed_run(input int n, input logic [63:0] mask, input string tag);
    int found, k;
    logic [AW-1:0] target;
    k = $countones(mask);
    target = AW'(4 * (n + 4));
    load_prog(n, mask);
    junk_pct = 0; stall_pct = 0;
    do_reset();
    found = -1;
    for (int c = 0; c < 120; c++) begin
      if (found < 0 && pc_o == target) found = c;
      step();
    end
    chk(tag, found, n + 4 + k);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) prog_mem[i] = 32'hC000_0000;
    model_reset();
    junk_pct = 0; stall_pct = 0;
    // R1 reset state, then R7 junk flags on the empty pipe
    do_reset();
    junk_pct = 100;
    repeat (3) step();
    // Random instruction mix with junk flags and freezes (R2..R9)
    for (int i = 0; i < 64; i++) begin
      case ($urandom % 4)
        0: prog_mem[i] = 32'h4000_0000 | ($urandom & 32'hFFF);
        1: prog_mem[i] = 32'h8000_0000 | ($urandom & 32'hFFF);
        default: prog_mem[i] = 32'hC000_0000 | ($urandom & 32'hFFF);
      endcase
    end
    junk_pct = 50; stall_pct = 12;
    repeat (2500) step();
    // Directed: freeze during a conflict (R6)
    stall_pct = 100;
    repeat (5) step();
    stall_pct = 0;
    repeat (20) step();
    // R10: completion time, none / scattered / back-to-back memory ops
    timed_run(20, 64'h0, "R10 no memops");
    timed_run(20, 64'h0_8421, "R10 scattered");
    timed_run(20, 64'h0_003F, "R10 consecutive");
    timed_run(20, 64'hF_FFFF, "R10 all memops");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule